// File: doc/BRIEF.md
# Secure-Aware Interrupt Priority Mask

This block holds the priority threshold of a processor-side interrupt interface and decides whether the highest pending interrupt is passed on to the processor. Priority values are 8 bits, and a smaller value means a more urgent interrupt. An interrupt is forwarded only when its value is strictly below the stored threshold. The threshold is reset to 0x00, so every interrupt is held back until software writes a threshold.

Software reaches the threshold through a 32-bit register port, and each request carries a secure attribute. Secure requests, and every request when the block is built for a single security state, read and write the stored value directly. When two security states are supported, a non-secure request sees only the less urgent half of the range (stored values 0x80 to 0xFF), through a one-bit scaling. It sees nothing at all once a secure write has left a threshold in the urgent half. Bits below the number of implemented priority levels always hold zero.

The request side uses a valid/ready handshake, and a request is accepted on a clock edge where both are high. Reads return data on a response channel with its own valid/ready pair. A response that has not been taken keeps its data stable and holds `req_ready` low, which is how back-pressure reaches the requester. Writes give no response.

Top module: `irq_prio_mask`

## Requirements
- R1: The threshold occupies bits [7:0] of the word at offset 0x004, and bits [31:8] read as zero. A read of any other offset returns 0, and a write to any other offset leaves the threshold unchanged.
- R2: `irq_fwd` is 1 exactly when `pend_valid` is 1 and `pend_prio` is strictly less than the stored threshold. An equal value is not forwarded.
- R3: With PRIO_LEVELS = 2^k, the low 8-k bits of the threshold always read as zero and ignore written ones. With the default of 32 levels, bits [2:0] are zero.
- R4: After reset the threshold is 0x00, `irq_fwd` is 0 for every pending priority, and `resp_valid` is 0.
- R5: With two security states and stored bit 7 equal to 1, a non-secure write of v stores ((v >> 1) | 0x80) with the unimplemented bits cleared. A non-secure read returns the stored value shifted left by one, truncated to 8 bits.
- R6: With two security states and stored bit 7 equal to 0, a non-secure read returns 0x00 and a non-secure write leaves the threshold unchanged.
- R7: Secure requests read the stored value unchanged and write v with only the unimplemented bits cleared.
- R8: An accepted write changes `irq_fwd` starting from the cycle after its accepting edge. `irq_fwd` follows `pend_valid` and `pend_prio` within the same cycle.
- R9: A read is answered with `resp_valid` high after its accepting edge. While `resp_valid` is 1 and `resp_ready` is 0, `req_ready` is 0 and `resp_rdata` stays stable.
- R10: With DUAL_SEC = 0, a request marked non-secure reads and writes the stored value exactly as a secure request would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A register request is presented |
| req_ready | output | 1 | The block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure request |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Read data is available |
| resp_ready | input | 1 | The requester takes the read data |
| resp_rdata | output | 32 | Read data |
| pend_valid | input | 1 | A pending interrupt is present |
| pend_prio | input | 8 | Priority of the highest pending interrupt |
| irq_fwd | output | 1 | Signal the pending interrupt to the processor |

## Verification
Two functions meet in one cycle: a write that is being accepted and the combinational forwarding decision, which still depends on the old threshold. The bench holds a pending priority between the old and new thresholds and presents a write. It samples `irq_fwd` after the inputs settle in the accepting cycle, where it must reflect the old threshold, and again one cycle later, where it must reflect the new one. A stalled response overlapping a new request is the second collision: the bench holds `resp_ready` low and checks that `req_ready` drops and the data holds until the response is taken.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int unsigned PRIO_W = 8;
  localparam int unsigned DATA_W = 32;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/pm_access.sv
module pm_access
  import pm_pkg::*;
#(
  parameter bit    DUAL_SEC = 1'b1,
  parameter prio_t IMPL     = 8'hF8
) (
  input  logic  secure,
  input  prio_t wval_in,
  input  prio_t cur_mask,
  output logic  wr_allow,
  output prio_t wr_val,
  output prio_t rd_view
);
  generate
    if (DUAL_SEC) begin : g_dual
      logic upper;
      assign upper = cur_mask[PRIO_W-1];
      always_comb begin
        if (secure) begin
          wr_allow = 1'b1;
          wr_val   = wval_in & IMPL;
          rd_view  = cur_mask;
        end else begin
          wr_allow = upper;
          wr_val   = ({1'b0, wval_in[PRIO_W-1:1]} | 8'h80) & IMPL;
          rd_view  = upper ? {cur_mask[PRIO_W-2:0], 1'b0} : '0;
        end
      end
    end else begin : g_single
      assign wr_allow = 1'b1;
      assign wr_val   = wval_in & IMPL;
      assign rd_view  = cur_mask;
    end
  endgenerate
endmodule

// File: rtl/pm_store.sv
module pm_store
  import pm_pkg::*;
#(
  parameter prio_t IMPL = 8'hF8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  prio_t wval,
  output prio_t mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else if (we) mask <= wval;
  end

  p_low_bits_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask & ~IMPL) == '0);
endmodule

// File: rtl/pm_filter.sv
module pm_filter
  import pm_pkg::*;
(
  input  logic  pend_valid,
  input  prio_t pend_prio,
  input  prio_t mask,
  output logic  fwd
);
  assign fwd = pend_valid && (pend_prio < mask);

  always_comb begin
    if (mask == '0) a_zero_blocks_r4: assert (!fwd);
  end
endmodule

// File: rtl/irq_prio_mask.sv
module irq_prio_mask
  import pm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned PRIO_LEVELS = 32,
  parameter bit          DUAL_SEC    = 1'b1,
  parameter int unsigned MASK_OFFSET = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_secure,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [31:0]       resp_rdata,
  input  logic              pend_valid,
  input  logic [7:0]        pend_prio,
  output logic              irq_fwd
);
  localparam int unsigned LOW_ZERO = PRIO_W - $clog2(PRIO_LEVELS);
  localparam prio_t       IMPL     = prio_t'(8'hFF << LOW_ZERO);

  logic  accept, hit, wr_allow;
  prio_t mask, wr_val, rd_view;

  assign req_ready = !resp_valid || resp_ready;
  assign accept    = req_valid && req_ready;
  assign hit       = (req_addr == ADDR_W'(MASK_OFFSET));

  pm_access #(.DUAL_SEC(DUAL_SEC), .IMPL(IMPL)) u_access (
    .secure  (req_secure),
    .wval_in (req_wdata[PRIO_W-1:0]),
    .cur_mask(mask),
    .wr_allow(wr_allow),
    .wr_val  (wr_val),
    .rd_view (rd_view)
  );

  pm_store #(.IMPL(IMPL)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (accept && req_write && hit && wr_allow),
    .wval (wr_val),
    .mask (mask)
  );

  pm_filter u_filter (
    .pend_valid(pend_valid),
    .pend_prio (pend_prio),
    .mask      (mask),
    .fwd       (irq_fwd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else if (accept && !req_write) begin
      resp_valid <= 1'b1;
      resp_rdata <= hit ? {{(DATA_W-PRIO_W){1'b0}}, rd_view} : '0;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

  p_stall_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_rdata)));
  p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |-> !req_ready);
  p_miss_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> $stable(mask));
  p_read_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write) |=> $stable(mask));
  p_ns_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (DUAL_SEC && accept && req_write && !req_secure && !mask[7]) |=> $stable(mask));
  p_ns_stays_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (DUAL_SEC && accept && req_write && !req_secure && mask[7]) |=> mask[7]);
endmodule

// File: tb/sim_irq_prio_mask.sv
module sim_irq_prio_mask;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_secure = 0, resp_ready = 1;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic pend_valid = 0;
  logic [7:0] pend_prio = '0;
  logic rdy0, rdy1, rv0, rv1, fwd0, fwd1;
  logic [31:0] rd0, rd1;
  int checks = 0, failures = 0, cycles = 0;
  logic [31:0] q0[$], q1[$];
  logic [7:0] m0 = 8'h00, m1 = 8'h00;

  always #10 clk = ~clk;

  irq_prio_mask u0 (.clk, .rst_n, .req_valid, .req_ready(rdy0), .req_write,
    .req_secure, .req_addr, .req_wdata, .resp_valid(rv0), .resp_ready,
    .resp_rdata(rd0), .pend_valid, .pend_prio, .irq_fwd(fwd0));
  irq_prio_mask #(.DUAL_SEC(1'b0)) u1 (.clk, .rst_n, .req_valid, .req_ready(rdy1),
    .req_write, .req_secure, .req_addr, .req_wdata, .resp_valid(rv1), .resp_ready,
    .resp_rdata(rd1), .pend_valid, .pend_prio, .irq_fwd(fwd1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compare each response when it is taken.
  always @(posedge clk) begin
    if (rst_n && rv0 && resp_ready) begin
      if (q0.size() == 0) chk("R9 unexpected response u0", 1, 0);
      else chk("R1/R5/R6/R7 read u0", rd0, q0.pop_front());
    end
    if (rst_n && rv1 && resp_ready) begin
      if (q1.size() == 0) chk("R10 unexpected response u1", 1, 0);
      else chk("R10 read u1", rd1, q1.pop_front());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Reference model from the requirements (32 levels: low 3 bits zero).
  function automatic logic [7:0] view(input logic [7:0] m, input logic sec, input logic dual);
    if (!dual || sec) return m;
    return m[7] ? {m[6:0], 1'b0} : 8'h00;
  endfunction
  function automatic logic [7:0] upd(input logic [7:0] m, input logic sec,
                                     input logic dual, input logic [7:0] v);
    if (!dual || sec) return v & 8'hF8;
    if (!m[7]) return m;
    return ({1'b0, v[7:1]} | 8'h80) & 8'hF8;
  endfunction

  task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d, input logic sec);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_secure = sec;
    while (!rdy0) @(negedge clk);
    if (wr) begin
      if (a == 12'h004) begin
        m0 = upd(m0, sec, 1'b1, d[7:0]);
        m1 = upd(m1, sec, 1'b0, d[7:0]);
      end
    end else begin
      q0.push_back(a == 12'h004 ? {24'h0, view(m0, sec, 1'b1)} : 32'h0);
      q1.push_back(a == 12'h004 ? {24'h0, view(m1, sec, 1'b0)} : 32'h0);
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    while (q0.size() != 0 || q1.size() != 0) @(negedge clk);
  endtask

  task automatic irq(input logic v, input logic [7:0] p, input logic exp, input string req);
    @(negedge clk);
    pend_valid = v; pend_prio = p;
    #1 chk(req, fwd0, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 resp_valid after reset", rv0, 0);
    chk("R4 irq_fwd after reset", fwd0, 0);
    rst_n = 1;
    irq(1, 8'h00, 0, "R4 mask 0 blocks priority 0");
    pend_valid = 0;
    xfer(0, 12'h004, 0, 1);                      // R4: secure read 0x00
    xfer(0, 12'h004, 0, 0);                      // R6: non-secure read 0x00
    xfer(1, 12'h004, 32'h47, 1);                 // R3/R7: stores 0x40
    xfer(0, 12'h004, 0, 1);
    chk("R3 model low bits", m0, 8'h40);
    xfer(0, 12'h004, 0, 0);                      // R6 on u0, R10 on u1
    xfer(1, 12'h004, 32'hFF, 0);                 // R6 ignored on u0, R10 u1 stores 0xF8
    xfer(0, 12'h004, 0, 1);
    xfer(0, 12'h004, 0, 0);
    drain();
    irq(1, 8'h3F, 1, "R2 below mask forwards");
    irq(1, 8'h40, 0, "R2 equal not forwarded");
    irq(0, 8'h00, 0, "R2 invalid not forwarded");
    xfer(1, 12'h004, 32'hC8, 1);                 // R7: 0xC8
    xfer(0, 12'h004, 0, 0);                      // R5: 0x90
    xfer(1, 12'h004, 32'h60, 0);                 // R5: 0xB0
    xfer(0, 12'h004, 0, 1);
    xfer(0, 12'h004, 0, 0);                      // R5: 0x60
    chk("R5 model scaled store", m0, 8'hB0);
    xfer(1, 12'h008, 32'h12, 1);                 // R1: other offset ignored
    xfer(0, 12'h008, 0, 1);                      // R1: reads 0
    xfer(0, 12'h004, 0, 1);                      // R1: still 0xB0
    xfer(1, 12'h004, 32'hFFFFFF10, 1);           // R1: upper bits not stored
    xfer(0, 12'h004, 0, 1);
    drain();
    // R8: write collides with forwarding decision
    pend_valid = 1; pend_prio = 8'h20;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 12'h004; req_wdata = 32'hF0; req_secure = 1;
    #1 chk("R8 old mask in accepting cycle", fwd0, 0);
    m0 = 8'hF0; m1 = 8'hF0;
    @(negedge clk);
    req_valid = 0;
    #1 chk("R8 new mask next cycle", fwd0, 1);
    pend_valid = 0;
    // R9: back-pressure
    @(negedge clk);
    resp_ready = 0;
    req_valid = 1; req_write = 0; req_addr = 12'h004; req_secure = 1;
    q0.push_back(32'hF0); q1.push_back(32'hF0);
    @(negedge clk);
    req_addr = 12'h008;
    #1 chk("R9 resp_valid raised", rv0, 1);
    chk("R9 req_ready low while stalled", rdy0, 0);
    @(negedge clk);
    chk("R9 data held while stalled", rd0, 32'hF0);
    chk("R9 still blocked", rdy0, 0);
    resp_ready = 1;
    q0.push_back(32'h0); q1.push_back(32'h0);
    @(negedge clk);
    req_valid = 0;
    drain();
    repeat (3) @(negedge clk);
    chk("R9 queue empty", q0.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule